// File: doc/BRIEF.md
# Energy-Efficient Ethernet Transmit Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC asks the encoder to send Low Power Idle (LPI) and when it stops. Software programs a 32-bit control/status word that holds four control bits: LPI enable, automatic mode, a software PHY-link-status bit and a link-status-qualify bit. The transmit datapath reports whether frames are still queued or in flight, a new frame request, and a transmit FIFO flush. The block drives `lpi_assert` to the encoder and raises an interrupt on LPI events.

In manual mode the enable bit alone drives the LPI state. In automatic mode the block waits until the transmit path is idle before it enters LPI. It leaves LPI on a new frame or on a flush and then clears its own enable bit. The same word also records transmit and receive LPI entry and exit events. These event flags clear when software reads the word. The block also forms the trigger for the link-status timer from the link status and the software status bit.

Top module: `eee_lpi_tx_ctrl`

## Requirements
- R1: After reset, `reg_rd_data` is 0, `lpi_assert` is 0 and `irq` is 0.
- R2: A write loads bit 19 (automatic mode), bit 18 (link-status qualify), bit 17 (PHY link status) and bit 16 (LPI enable). The read-only bits (31:20, 15:0) ignore writes. The read layout is: bit 9 is the receive LPI state, bit 8 is the transmit LPI state, and bits 3..0 are the receive-exit, receive-entry, transmit-exit and transmit-entry flags.
- R3: With automatic mode clear, `lpi_assert` rises on the clock edge after the one that sets LPI enable. It falls on the clock edge after the one that clears LPI enable.
- R4: With automatic mode and enable set, LPI is not entered while `tx_busy` or `tx_frame_req` is high. It is entered on the first edge where both are low.
- R5: In automatic mode, a `tx_frame_req` while in LPI ends LPI on that edge and clears LPI enable.
- R6: A `tx_fifo_flush` while in LPI ends LPI on that edge and clears LPI enable, in either mode.
- R7: When the hardware clears LPI enable in the same cycle as a software write, the hardware clear wins.
- R8: Entering transmit LPI sets bit 0. Leaving it sets bit 1. Bit 8 follows `lpi_assert`.
- R9: A rise of `rx_lpi_active` sets bit 2, and a fall sets bit 3. Bit 9 shows the receive state one cycle after the input changes.
- R10: A read (`reg_rd_en`) returns the flags and then clears them. A flag event in the same cycle as a read stays set.
- R11: `irq` is the OR of flag bits 3..0.
- R12: `ls_trigger` equals bit 17 when bit 18 is clear, and bit 17 AND `rx_link_up` when bit 18 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe; clears the event flags |
| reg_rd_data | output | 32 | Current control/status word |
| tx_busy | input | 1 | Frames are outstanding or queued in the transmit path |
| tx_frame_req | input | 1 | New frame submitted for transmission |
| tx_fifo_flush | input | 1 | Transmit FIFO flush command |
| rx_lpi_active | input | 1 | Receive side currently sees LPI |
| rx_link_up | input | 1 | Link status recovered from the receive path |
| lpi_assert | output | 1 | Request to the encoder to send LPI |
| ls_trigger | output | 1 | Trigger for the link-status timer |
| irq | output | 1 | Interrupt, high while any event flag is set |

## Verification
The bench holds `tx_busy` high with automatic mode enabled. A design that ignores the drain condition would enter LPI early. It then raises a frame request and a software write in the same cycle. If the design let the write win, enable would stay set. It also lines up a receive LPI exit with a read. A design that cleared on read without first accepting the event would lose the exit flag. A flush in manual mode checks that the enable is dropped; otherwise the block would fall straight back into LPI.

// File: rtl/eee_lpi_tx_ctrl.sv
module eee_lpi_tx_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_rd_en,
  output logic [31:0] reg_rd_data,
  input  logic        tx_busy,
  input  logic        tx_frame_req,
  input  logic        tx_fifo_flush,
  input  logic        rx_lpi_active,
  input  logic        rx_link_up,
  output logic        lpi_assert,
  output logic        ls_trigger,
  output logic        irq
);
  localparam int BIT_AUTO = 19;
  localparam int BIT_LSQ  = 18;
  localparam int BIT_PLS  = 17;
  localparam int BIT_EN   = 16;

  logic       auto_mode, ls_qual, pls, lpi_en;
  logic       tx_lpi, rx_lpi_q;
  logic [3:0] flags;
  logic       enter, leave, hw_clr;
  logic [3:0] events;

  assign hw_clr = tx_lpi & (tx_fifo_flush | (auto_mode & tx_frame_req));
  assign leave  = tx_lpi & (hw_clr | ~lpi_en);
  assign enter  = ~tx_lpi & lpi_en & ~tx_fifo_flush &
                  (~auto_mode | (~tx_busy & ~tx_frame_req));

  assign events = {~rx_lpi_active & rx_lpi_q, rx_lpi_active & ~rx_lpi_q, leave, enter};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_mode <= 1'b0;
      ls_qual   <= 1'b0;
      pls       <= 1'b0;
      lpi_en    <= 1'b0;
    end else begin
      if (reg_wr_en) begin
        auto_mode <= reg_wr_data[BIT_AUTO];
        ls_qual   <= reg_wr_data[BIT_LSQ];
        pls       <= reg_wr_data[BIT_PLS];
        lpi_en    <= reg_wr_data[BIT_EN];
      end
      if (hw_clr) lpi_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lpi   <= 1'b0;
      rx_lpi_q <= 1'b0;
      flags    <= '0;
    end else begin
      if (enter)      tx_lpi <= 1'b1;
      else if (leave) tx_lpi <= 1'b0;
      rx_lpi_q <= rx_lpi_active;
      flags    <= events | (flags & {4{~reg_rd_en}});
    end
  end

  assign reg_rd_data = {12'd0, auto_mode, ls_qual, pls, lpi_en,
                        6'd0, rx_lpi_q, tx_lpi, 4'd0, flags};
  assign lpi_assert  = tx_lpi;
  assign ls_trigger  = pls & (~ls_qual | rx_link_up);
  assign irq         = |flags;
endmodule

module eee_lpi_tx_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rd_data,
  input logic        tx_busy,
  input logic        tx_fifo_flush,
  input logic        lpi_assert,
  input logic        irq
);
  AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_assert) |-> reg_rd_data[0]); // R8
  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|reg_rd_data[3:0])); // R11
  AST_FLUSH_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_assert && tx_fifo_flush) |=> (!lpi_assert && !reg_rd_data[16])); // R6
  AST_DISABLE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_assert && !reg_rd_data[16]) |=> !lpi_assert); // R3
  AST_AUTO_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lpi_assert && reg_rd_data[19] && tx_busy) |=> !lpi_assert); // R4
endmodule

bind eee_lpi_tx_ctrl eee_lpi_tx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd_data(reg_rd_data), .tx_busy(tx_busy),
  .tx_fifo_flush(tx_fifo_flush), .lpi_assert(lpi_assert), .irq(irq));

// File: tb/tb_eee_lpi_tx_ctrl.sv
module tb_eee_lpi_tx_ctrl;
  localparam int PER = 10;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [31:0] reg_wr_data = 0;
  logic [31:0] reg_rd_data;
  logic tx_busy = 0, tx_frame_req = 0, tx_fifo_flush = 0, rx_lpi_active = 0, rx_link_up = 0;
  logic lpi_assert, ls_trigger, irq;
  int checks = 0, errors = 0;

  always #(PER/2) clk = ~clk;

  eee_lpi_tx_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0;
    tx_busy = 0; tx_frame_req = 0; tx_fifo_flush = 0; rx_lpi_active = 0; rx_link_up = 0;
    step(); rst_n = 1;
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr_en = 1; reg_wr_data = d;
    step(); reg_wr_en = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    reg_rd_en = 1; #1 v = reg_rd_data;
    step(); reg_rd_en = 0;
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 data", reg_rd_data, 0);
    chk("R1 lpi", {31'd0, lpi_assert}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    reset_dut();
    wr(32'hFFFE_FFFF);
    chk("R2 ro bits ignored", reg_rd_data, 32'h000E_0000);
    wr(32'h0001_0000);
    chk("R2 enable readback", reg_rd_data & 32'hFFFF_0000, 32'h0001_0000);
  endtask

  task automatic t_ls();
    reset_dut();
    wr(32'h0002_0000);
    chk("R12 pls only", {31'd0, ls_trigger}, 1);
    wr(32'h0006_0000);
    chk("R12 qualified, link down", {31'd0, ls_trigger}, 0);
    rx_link_up = 1; #1;
    chk("R12 qualified, link up", {31'd0, ls_trigger}, 1);
    wr(32'h0004_0000);
    chk("R12 pls clear", {31'd0, ls_trigger}, 0);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    reset_dut();
    wr(32'h0001_0000);
    chk("R3 not yet", {31'd0, lpi_assert}, 0);
    step();
    chk("R3 entered", {31'd0, lpi_assert}, 1);
    chk("R11 irq on entry", {31'd0, irq}, 1);
    rd(v);
    chk("R8 entry flag and state", v, 32'h0001_0101);
    chk("R10 cleared by read", reg_rd_data & 32'hF, 0);
    chk("R11 irq low", {31'd0, irq}, 0);
    wr(32'h0);
    chk("R3 still in lpi", {31'd0, lpi_assert}, 1);
    step();
    chk("R3 exited", {31'd0, lpi_assert}, 0);
    rd(v);
    chk("R8 exit flag", v, 32'h0000_0002);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    reset_dut();
    tx_busy = 1;
    wr(32'h0009_0000);
    step(); step(); step();
    chk("R4 waits while busy", {31'd0, lpi_assert}, 0);
    tx_busy = 0; tx_frame_req = 1;
    step();
    chk("R4 waits on frame request", {31'd0, lpi_assert}, 0);
    tx_frame_req = 0;
    step();
    chk("R4 entered when idle", {31'd0, lpi_assert}, 1);
    rd(v);
    tx_frame_req = 1;
    step(); tx_frame_req = 0;
    chk("R5 exit on frame", {31'd0, lpi_assert}, 0);
    rd(v);
    chk("R5 enable cleared, exit flag", v, 32'h0008_0002);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    reset_dut();
    wr(32'h0001_0000);
    step();
    chk("R6 in lpi", {31'd0, lpi_assert}, 1);
    rd(v);
    tx_fifo_flush = 1;
    step(); tx_fifo_flush = 0;
    chk("R6 flush exit", {31'd0, lpi_assert}, 0);
    step(); step();
    rd(v);
    chk("R6 enable cleared, stays out", v, 32'h0000_0002);
  endtask

  task automatic t_hwpri();
    logic [31:0] v;
    reset_dut();
    wr(32'h0009_0000);
    step();
    rd(v);
    reg_wr_en = 1; reg_wr_data = 32'h0009_0000; tx_frame_req = 1;
    step(); reg_wr_en = 0; tx_frame_req = 0;
    chk("R7 hw clear wins", reg_rd_data & 32'hFFFF_0000, 32'h0008_0000);
    chk("R7 out of lpi", {31'd0, lpi_assert}, 0);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    reset_dut();
    rx_lpi_active = 1;
    step();
    chk("R9 rx entry and state", reg_rd_data, 32'h0000_0204);
    rx_lpi_active = 0;
    rd(v);
    chk("R10 read value", v, 32'h0000_0204);
    chk("R10 event kept over read", reg_rd_data, 32'h0000_0008);
  endtask

  initial begin
    #(PER * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_ls();
    t_manual();
    t_auto();
    t_flush();
    t_hwpri();
    t_rx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule